// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block decides whether a pending interrupt may be taken and computes the processor-state updates that taking it implies. It is combinational up to a single register stage. The pending level is accepted when it exceeds the current interrupt level, does not exceed the number of levels the configuration supports, and at least one interrupt line of that level is both raised and enabled. On the clock edge where the evaluate strobe is high and the interrupt qualifies, every resulting write is issued at once and a one-cycle taken pulse marks the event.

Interrupts above level 1 are vectored. The current program counter and status word are saved into the save slots of the taken level. The status word gets the new interrupt level and the exception-mode bit. The program counter moves to the level's vector, optionally rebased against a runtime vector-base register. Level-1 interrupts are not vectored here. They are reported as a user, kernel or double exception according to the status mode bits, with a fixed cause code and the program counter saved into the matching slot. The surrounding core consumes the write strobes and data.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only when `pend_level` is strictly greater than `cur_level`; equal or lower levels produce no write.
- R2: A `pend_level` above NLEVELS is never taken, whatever the interrupt lines show.
- R3: An interrupt is taken only when the mask slice of the pending level (bits `[l*NIRQ +: NIRQ]` of `level_mask`) ANDed with `intset` and `intenable` is nonzero.
- R4: For a taken level L above 1, `epc_wr` and `eps_wr` pulse with `save_idx` = L, `save_pc` = `pc_in` and `save_ps` = `ps_in`.
- R5: For a taken level L above 1, `ps_new` equals `ps_in` with bits [3:0] replaced by L and bit 4 (exception mode) set; `ps_wr` pulses.
- R6: For a taken level L above 1, `pc_wr` pulses and `pc_new` is entry L of `vec_tbl` (bits `[L*DW +: DW]`); with RELOC=1 it is that entry minus DEF_VECBASE plus `vecbase`.
- R7: For a taken level-1 interrupt, `cause_wr` pulses with `cause` = L1_CAUSE (4 by default); `pc_wr` stays low; `ps_new` is `ps_in` with bit 4 set.
- R8: A taken level-1 interrupt with status bit 4 already set is a double exception (`exc_class` = 3). The program counter goes to `save_pc` with `depc_wr` when HAS_DEPC=1, otherwise with `epc_wr` and `save_idx` = 1.
- R9: A taken level-1 interrupt with status bit 4 clear pulses `epc_wr` with `save_idx` = 1. `exc_class` is 1 (user) when status bit 5 is set and 2 (kernel) otherwise. Above level 1 `exc_class` is 0.
- R10: All strobes, including `taken`, are registered and last exactly one cycle after an evaluation edge. They are low out of reset, when `eval` is low, and when nothing qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eval | input | 1 | Evaluate strobe; updates commit on this edge |
| pend_level | input | LVL_W | Level of the highest pending interrupt |
| cur_level | input | LVL_W | Current interrupt level |
| intset | input | NIRQ | Raised interrupt lines |
| intenable | input | NIRQ | Enabled interrupt lines |
| level_mask | input | (NLEVELS+1)*NIRQ | Per-level line masks, level l at `[l*NIRQ +: NIRQ]` |
| ps_in | input | DW | Current status word |
| pc_in | input | DW | Current program counter |
| vecbase | input | DW | Runtime vector-base register |
| vec_tbl | input | (NLEVELS+1)*DW | Per-level vectors, level l at `[l*DW +: DW]` |
| taken | output | 1 | One-cycle pulse when an interrupt is taken |
| pc_wr | output | 1 | Program-counter write strobe |
| pc_new | output | DW | New program counter |
| ps_wr | output | 1 | Status-word write strobe |
| ps_new | output | DW | New status word |
| epc_wr | output | 1 | Per-level saved-PC write strobe |
| depc_wr | output | 1 | Double-exception saved-PC write strobe |
| eps_wr | output | 1 | Per-level saved-status write strobe |
| save_idx | output | LVL_W | Level selecting the save slot |
| save_pc | output | DW | Program counter to save |
| save_ps | output | DW | Status word to save |
| cause_wr | output | 1 | Exception-cause write strobe |
| cause | output | CAUSE_W | Exception-cause value |
| exc_class | output | 2 | 0 none, 1 user, 2 kernel, 3 double |

## Verification
The bench builds two instances on the same stimulus. One uses the defaults: six levels, a dedicated double-exception save slot, and vector relocation against a nonzero default base. The other drops the double-exception slot and relocation. The pair covers both placements of a double exception's program counter, and relocated and raw vectors side by side. Four-bit level inputs reach values above the configured six, so the upper-bound rejection is exercised as well as the top valid level.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
    typedef enum logic [1:0] {
        XC_NONE   = 2'd0,
        XC_USER   = 2'd1,
        XC_KERNEL = 2'd2,
        XC_DOUBLE = 2'd3
    } xclass_e;

    // status word layout
    localparam int PS_LVL_W = 4;
    localparam int PS_EXCM  = 4;
    localparam int PS_UM    = 5;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NLEVELS = 6,
    parameter int NIRQ    = 32,
    parameter int LVL_W   = 4
) (
    input  logic [LVL_W-1:0]            pend_level,
    input  logic [LVL_W-1:0]            cur_level,
    input  logic [(NLEVELS+1)*NIRQ-1:0] level_mask,
    input  logic [NIRQ-1:0]             intset,
    input  logic [NIRQ-1:0]             intenable,
    output logic                        take
);
    localparam logic [LVL_W:0] MAX_LVL = (LVL_W+1)'(NLEVELS);

    logic [NIRQ-1:0] lvl_hit [NLEVELS+1];
    logic [NIRQ-1:0] sel_mask;

    // one mask slice per level, gated by the level decode
    for (genvar l = 0; l <= NLEVELS; l++) begin : g_lvl
        assign lvl_hit[l] = (pend_level == LVL_W'(l)) ? level_mask[l*NIRQ +: NIRQ] : '0;
    end

    always_comb begin
        sel_mask = '0;
        for (int l = 0; l <= NLEVELS; l++) begin
            sel_mask = sel_mask | lvl_hit[l];
        end
    end

    assign take = (pend_level > cur_level)
               && ({1'b0, pend_level} <= MAX_LVL)
               && (|(sel_mask & intset & intenable));
endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc #(
    parameter int          NLEVELS     = 6,
    parameter int          LVL_W       = 4,
    parameter int          DW          = 32,
    parameter bit          RELOC       = 1'b1,
    parameter logic [31:0] DEF_VECBASE = 32'h4000_0000
) (
    input  logic [LVL_W-1:0]          level,
    input  logic [(NLEVELS+1)*DW-1:0] vec_tbl,
    input  logic [DW-1:0]             vecbase,
    output logic [DW-1:0]             target
);
    logic [DW-1:0] raw_vec;

    always_comb begin
        raw_vec = '0;
        for (int l = 0; l <= NLEVELS; l++) begin
            if (level == LVL_W'(l)) raw_vec = vec_tbl[l*DW +: DW];
        end
    end

    if (RELOC) begin : g_reloc
        assign target = raw_vec - DW'(DEF_VECBASE) + vecbase;
    end else begin : g_fixed
        assign target = raw_vec;
    end
endmodule

// File: rtl/irq_state_next.sv
module irq_state_next
    import irq_disp_pkg::*;
#(
    parameter int LVL_W    = 4,
    parameter int DW       = 32,
    parameter int CAUSE_W  = 6,
    parameter int L1_CAUSE = 4,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [DW-1:0]      ps,
    input  logic [DW-1:0]      pc,
    input  logic [DW-1:0]      target,
    output logic               pc_wr,
    output logic [DW-1:0]      pc_new,
    output logic [DW-1:0]      ps_new,
    output logic               epc_wr,
    output logic               depc_wr,
    output logic               eps_wr,
    output logic [LVL_W-1:0]   save_idx,
    output logic [DW-1:0]      save_pc,
    output logic [DW-1:0]      save_ps,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause,
    output xclass_e            cls
);
    logic hi_lvl;
    logic dbl;
    logic dbl_to_depc;

    assign hi_lvl = (level > LVL_W'(1));
    assign dbl    = !hi_lvl && ps[PS_EXCM];

    if (HAS_DEPC) begin : g_depc
        assign dbl_to_depc = dbl;
    end else begin : g_no_depc
        assign dbl_to_depc = 1'b0;
    end

    always_comb begin
        pc_wr    = hi_lvl;
        pc_new   = hi_lvl ? target : pc;
        ps_new   = ps;
        ps_new[PS_EXCM] = 1'b1;
        if (hi_lvl) ps_new[PS_LVL_W-1:0] = PS_LVL_W'(level);
        eps_wr   = hi_lvl;
        depc_wr  = dbl_to_depc;
        epc_wr   = !dbl_to_depc;
        save_idx = hi_lvl ? level : LVL_W'(1);
        save_pc  = pc;
        save_ps  = ps;
        cause_wr = !hi_lvl;
        cause    = hi_lvl ? '0 : CAUSE_W'(L1_CAUSE);
        if (hi_lvl)          cls = XC_NONE;
        else if (dbl)        cls = XC_DOUBLE;
        else if (ps[PS_UM])  cls = XC_USER;
        else                 cls = XC_KERNEL;
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_disp_pkg::*;
#(
    parameter int          NLEVELS     = 6,
    parameter int          NIRQ        = 32,
    parameter int          LVL_W       = 4,
    parameter int          DW          = 32,
    parameter int          CAUSE_W     = 6,
    parameter int          L1_CAUSE    = 4,
    parameter bit          HAS_DEPC    = 1'b1,
    parameter bit          RELOC       = 1'b1,
    parameter logic [31:0] DEF_VECBASE = 32'h4000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eval,
    input  logic [LVL_W-1:0]            pend_level,
    input  logic [LVL_W-1:0]            cur_level,
    input  logic [NIRQ-1:0]             intset,
    input  logic [NIRQ-1:0]             intenable,
    input  logic [(NLEVELS+1)*NIRQ-1:0] level_mask,
    input  logic [DW-1:0]               ps_in,
    input  logic [DW-1:0]               pc_in,
    input  logic [DW-1:0]               vecbase,
    input  logic [(NLEVELS+1)*DW-1:0]   vec_tbl,
    output logic                        taken,
    output logic                        pc_wr,
    output logic [DW-1:0]               pc_new,
    output logic                        ps_wr,
    output logic [DW-1:0]               ps_new,
    output logic                        epc_wr,
    output logic                        depc_wr,
    output logic                        eps_wr,
    output logic [LVL_W-1:0]            save_idx,
    output logic [DW-1:0]               save_pc,
    output logic [DW-1:0]               save_ps,
    output logic                        cause_wr,
    output logic [CAUSE_W-1:0]          cause,
    output logic [1:0]                  exc_class
);
    typedef struct packed {
        logic               taken;
        logic               pc_wr;
        logic               ps_wr;
        logic               epc_wr;
        logic               depc_wr;
        logic               eps_wr;
        logic               cause_wr;
        logic [DW-1:0]      pc_new;
        logic [DW-1:0]      ps_new;
        logic [DW-1:0]      save_pc;
        logic [DW-1:0]      save_ps;
        logic [LVL_W-1:0]   save_idx;
        logic [CAUSE_W-1:0] cause;
        xclass_e            cls;
    } disp_t;

    disp_t d, q;

    logic               take;
    logic [DW-1:0]      vec_target;
    logic               nx_pc_wr, nx_epc_wr, nx_depc_wr, nx_eps_wr, nx_cause_wr;
    logic [DW-1:0]      nx_pc, nx_ps, nx_save_pc, nx_save_ps;
    logic [LVL_W-1:0]   nx_idx;
    logic [CAUSE_W-1:0] nx_cause;
    xclass_e            nx_cls;

    irq_qualify #(.NLEVELS(NLEVELS), .NIRQ(NIRQ), .LVL_W(LVL_W)) u_qual (
        .pend_level (pend_level),
        .cur_level  (cur_level),
        .level_mask (level_mask),
        .intset     (intset),
        .intenable  (intenable),
        .take       (take)
    );

    irq_vec_reloc #(
        .NLEVELS(NLEVELS), .LVL_W(LVL_W), .DW(DW),
        .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE)
    ) u_vec (
        .level   (pend_level),
        .vec_tbl (vec_tbl),
        .vecbase (vecbase),
        .target  (vec_target)
    );

    irq_state_next #(
        .LVL_W(LVL_W), .DW(DW), .CAUSE_W(CAUSE_W),
        .L1_CAUSE(L1_CAUSE), .HAS_DEPC(HAS_DEPC)
    ) u_next (
        .level    (pend_level),
        .ps       (ps_in),
        .pc       (pc_in),
        .target   (vec_target),
        .pc_wr    (nx_pc_wr),
        .pc_new   (nx_pc),
        .ps_new   (nx_ps),
        .epc_wr   (nx_epc_wr),
        .depc_wr  (nx_depc_wr),
        .eps_wr   (nx_eps_wr),
        .save_idx (nx_idx),
        .save_pc  (nx_save_pc),
        .save_ps  (nx_save_ps),
        .cause_wr (nx_cause_wr),
        .cause    (nx_cause),
        .cls      (nx_cls)
    );

    always_comb begin
        d          = q;
        d.taken    = 1'b0;
        d.pc_wr    = 1'b0;
        d.ps_wr    = 1'b0;
        d.epc_wr   = 1'b0;
        d.depc_wr  = 1'b0;
        d.eps_wr   = 1'b0;
        d.cause_wr = 1'b0;
        if (eval && take) begin
            d.taken    = 1'b1;
            d.pc_wr    = nx_pc_wr;
            d.ps_wr    = 1'b1;
            d.epc_wr   = nx_epc_wr;
            d.depc_wr  = nx_depc_wr;
            d.eps_wr   = nx_eps_wr;
            d.cause_wr = nx_cause_wr;
            d.pc_new   = nx_pc;
            d.ps_new   = nx_ps;
            d.save_pc  = nx_save_pc;
            d.save_ps  = nx_save_ps;
            d.save_idx = nx_idx;
            d.cause    = nx_cause;
            d.cls      = nx_cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign taken     = q.taken;
    assign pc_wr     = q.pc_wr;
    assign pc_new    = q.pc_new;
    assign ps_wr     = q.ps_wr;
    assign ps_new    = q.ps_new;
    assign epc_wr    = q.epc_wr;
    assign depc_wr   = q.depc_wr;
    assign eps_wr    = q.eps_wr;
    assign save_idx  = q.save_idx;
    assign save_pc   = q.save_pc;
    assign save_ps   = q.save_ps;
    assign cause_wr  = q.cause_wr;
    assign cause     = q.cause;
    assign exc_class = q.cls;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
    import irq_disp_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval,
    input logic [LVL_W-1:0] pend_level,
    input logic [LVL_W-1:0] cur_level,
    input logic [DW-1:0]    ps_in,
    input logic [DW-1:0]    pc_in,
    input logic             taken,
    input logic             pc_wr,
    input logic             ps_wr,
    input logic [DW-1:0]    ps_new,
    input logic             epc_wr,
    input logic             depc_wr,
    input logic             eps_wr,
    input logic [DW-1:0]    save_pc,
    input logic [DW-1:0]    save_ps,
    input logic             cause_wr,
    input logic [1:0]       exc_class
);
    // R10
    taken_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> $past(eval));

    // R10
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> !(pc_wr || ps_wr || epc_wr || depc_wr || eps_wr || cause_wr));

    // R1
    level_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ($past(pend_level) > $past(cur_level)));

    // R5
    hi_ps_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && pc_wr) |-> (ps_new[PS_EXCM] &&
            ps_new[PS_LVL_W-1:0] == PS_LVL_W'($past(pend_level))));

    // R4
    hi_save_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eps_wr |-> (epc_wr && save_ps == $past(ps_in) && save_pc == $past(pc_in)));

    // R7
    lvl1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |-> (!pc_wr && exc_class != 2'd0 && ps_new[PS_EXCM]));

    // R8
    one_pc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ($countones({epc_wr, depc_wr}) == 1));
endmodule

bind irq_dispatch irq_dispatch_chk #(.LVL_W(LVL_W), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (eval),
    .pend_level (pend_level),
    .cur_level  (cur_level),
    .ps_in      (ps_in),
    .pc_in      (pc_in),
    .taken      (taken),
    .pc_wr      (pc_wr),
    .ps_wr      (ps_wr),
    .ps_new     (ps_new),
    .epc_wr     (epc_wr),
    .depc_wr    (depc_wr),
    .eps_wr     (eps_wr),
    .save_pc    (save_pc),
    .save_ps    (save_ps),
    .cause_wr   (cause_wr),
    .exc_class  (exc_class)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
    localparam int NL = 6;
    localparam int NI = 32;
    localparam int LW = 4;
    localparam int DW = 32;
    localparam logic [31:0] DEFVB = 32'h4000_0000;

    typedef struct {
        bit          taken, pc_wr, epc_wr, depc_wr, eps_wr, cause_wr;
        logic [31:0] pc_new, ps_new, save_pc, save_ps;
        int          idx, cause, cls;
    } exp_t;

    typedef struct {
        exp_t  e0;
        exp_t  e1;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval = 1'b0;
    logic chk_pulse = 1'b0;
    logic chk_q;
    logic [LW-1:0] pend_level = '0, cur_level = '0;
    logic [NI-1:0] intset = '0, intenable = '0;
    logic [(NL+1)*NI-1:0] level_mask;
    logic [DW-1:0] ps_in = '0, pc_in = '0, vecbase = '0;
    logic [(NL+1)*DW-1:0] vec_tbl;

    logic a_tk, a_pcw, a_psw, a_epw, a_dpw, a_esw, a_cw;
    logic [DW-1:0] a_pcn, a_psn, a_spc, a_sps;
    logic [LW-1:0] a_idx;
    logic [5:0] a_cause;
    logic [1:0] a_cls;
    logic b_tk, b_pcw, b_psw, b_epw, b_dpw, b_esw, b_cw;
    logic [DW-1:0] b_pcn, b_psn, b_spc, b_sps;
    logic [LW-1:0] b_idx;
    logic [5:0] b_cause;
    logic [1:0] b_cls;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    item_t sb[$];

    always #10 clk = ~clk;

    function automatic logic [31:0] mask_of(int l);
        return 32'hF << (4 * l);
    endfunction
    function automatic logic [31:0] vec_of(int l);
        return 32'h4000_0100 + 32'(l) * 32'h40;
    endfunction

    always_comb begin
        for (int l = 0; l <= NL; l++) begin
            level_mask[l*NI +: NI] = mask_of(l);
            vec_tbl[l*DW +: DW]    = vec_of(l);
        end
    end

    irq_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .eval(eval), .pend_level(pend_level), .cur_level(cur_level),
        .intset(intset), .intenable(intenable), .level_mask(level_mask), .ps_in(ps_in),
        .pc_in(pc_in), .vecbase(vecbase), .vec_tbl(vec_tbl), .taken(a_tk), .pc_wr(a_pcw),
        .pc_new(a_pcn), .ps_wr(a_psw), .ps_new(a_psn), .epc_wr(a_epw), .depc_wr(a_dpw),
        .eps_wr(a_esw), .save_idx(a_idx), .save_pc(a_spc), .save_ps(a_sps),
        .cause_wr(a_cw), .cause(a_cause), .exc_class(a_cls)
    );

    irq_dispatch #(.HAS_DEPC(1'b0), .RELOC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .eval(eval), .pend_level(pend_level), .cur_level(cur_level),
        .intset(intset), .intenable(intenable), .level_mask(level_mask), .ps_in(ps_in),
        .pc_in(pc_in), .vecbase(vecbase), .vec_tbl(vec_tbl), .taken(b_tk), .pc_wr(b_pcw),
        .pc_new(b_pcn), .ps_wr(b_psw), .ps_new(b_psn), .epc_wr(b_epw), .depc_wr(b_dpw),
        .eps_wr(b_esw), .save_idx(b_idx), .save_pc(b_spc), .save_ps(b_sps),
        .cause_wr(b_cw), .cause(b_cause), .exc_class(b_cls)
    );

    always_ff @(posedge clk) chk_q <= chk_pulse;

    function automatic exp_t model(int pl, int cl, logic [31:0] iset, logic [31:0] ien,
                                   logic [31:0] ps, logic [31:0] pc, logic [31:0] vb,
                                   bit has_depc, bit reloc);
        exp_t e;
        e = '{default: 0};
        if (pl > cl && pl <= NL && (mask_of(pl) & iset & ien) != 0) begin
            e.taken   = 1;
            e.save_pc = pc;
            if (pl > 1) begin
                e.pc_wr   = 1;
                e.pc_new  = reloc ? vec_of(pl) - DEFVB + vb : vec_of(pl);
                e.ps_new  = (ps & ~32'hF) | 32'(pl) | 32'h10;
                e.epc_wr  = 1;
                e.eps_wr  = 1;
                e.idx     = pl;
                e.save_ps = ps;
                e.cls     = 0;
            end else begin
                e.cause_wr = 1;
                e.cause    = 4;
                e.ps_new   = ps | 32'h10;
                e.idx      = 1;
                if (ps[4]) begin
                    e.cls = 3;
                    if (has_depc) e.depc_wr = 1;
                    else          e.epc_wr  = 1;
                end else begin
                    e.epc_wr = 1;
                    e.cls    = ps[5] ? 1 : 2;
                end
            end
        end
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic cmp(string req, exp_t e, logic tk, logic pcw, logic psw, logic epw,
                       logic dpw, logic esw, logic cw, logic [31:0] pcn, logic [31:0] psn,
                       logic [31:0] spc, logic [31:0] sps, logic [3:0] idx, logic [5:0] cs,
                       logic [1:0] cls);
        chk(tk == e.taken, req, "taken", tk, e.taken);
        chk(pcw == e.pc_wr, req, "pc_wr", pcw, e.pc_wr);
        chk(psw == e.taken, req, "ps_wr", psw, e.taken);
        chk(epw == e.epc_wr, req, "epc_wr", epw, e.epc_wr);
        chk(dpw == e.depc_wr, req, "depc_wr", dpw, e.depc_wr);
        chk(esw == e.eps_wr, req, "eps_wr", esw, e.eps_wr);
        chk(cw == e.cause_wr, req, "cause_wr", cw, e.cause_wr);
        if (e.taken) begin
            chk(psn == e.ps_new, req, "ps_new", psn, e.ps_new);
            chk(spc == e.save_pc, req, "save_pc", spc, e.save_pc);
            chk(int'(cls) == e.cls, req, "exc_class", cls, e.cls);
        end
        if (e.pc_wr) chk(pcn == e.pc_new, req, "pc_new", pcn, e.pc_new);
        if (e.eps_wr) chk(sps == e.save_ps, req, "save_ps", sps, e.save_ps);
        if (e.epc_wr) chk(int'(idx) == e.idx, req, "save_idx", idx, e.idx);
        if (e.cause_wr) chk(int'(cs) == e.cause, req, "cause", cs, e.cause);
    endtask

    // driver: one evaluation (or a deliberately silent cycle when ev = 0)
    task automatic drive(string req, bit ev, int pl, int cl, logic [31:0] iset,
                         logic [31:0] ien, logic [31:0] ps, logic [31:0] pc, logic [31:0] vb);
        item_t it;
        exp_t  none;
        none = '{default: 0};
        @(negedge clk);
        pend_level = LW'(pl);
        cur_level  = LW'(cl);
        intset     = iset;
        intenable  = ien;
        ps_in      = ps;
        pc_in      = pc;
        vecbase    = vb;
        eval       = ev;
        chk_pulse  = 1'b1;
        it.e0  = ev ? model(pl, cl, iset, ien, ps, pc, vb, 1, 1) : none;
        it.e1  = ev ? model(pl, cl, iset, ien, ps, pc, vb, 0, 0) : none;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        eval      = 1'b0;
        chk_pulse = 1'b0;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (chk_q && sb.size() > 0) begin
                    item_t it;
                    it = sb.pop_front();
                    cmp({it.req, " u0"}, it.e0, a_tk, a_pcw, a_psw, a_epw, a_dpw, a_esw, a_cw,
                        a_pcn, a_psn, a_spc, a_sps, a_idx, a_cause, a_cls);
                    cmp({it.req, " u1"}, it.e1, b_tk, b_pcw, b_psw, b_epw, b_dpw, b_esw, b_cw,
                        b_pcn, b_psn, b_spc, b_sps, b_idx, b_cause, b_cls);
                end else begin
                    // R10: strobes quiet between evaluations
                    chk(!(a_tk | a_pcw | a_psw | a_epw | a_dpw | a_esw | a_cw), "R10",
                        "idle strobes u0", {a_tk, a_pcw, a_psw, a_epw, a_dpw, a_esw, a_cw}, 0);
                    chk(!(b_tk | b_pcw | b_psw | b_epw | b_dpw | b_esw | b_cw), "R10",
                        "idle strobes u1", {b_tk, b_pcw, b_psw, b_epw, b_dpw, b_esw, b_cw}, 0);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(a_tk == 0 && a_pcn == 0 && a_psn == 0, "R10", "reset u0", {a_tk, a_pcn}, 0);
        // R4 R5 R6: level 3 with relocation
        drive("R4 R5 R6", 1, 3, 1, 32'h0000_1000, 32'hFFFF_FFFF, 32'h0000_0061, 32'h1234_5678, 32'h8000_0000);
        // R6: top valid level 6, different base
        drive("R6 R2 top", 1, 6, 5, 32'h0100_0000, 32'hFFFF_FFFF, 32'h0000_0025, 32'hCAFE_0000, 32'h4000_0000);
        // R6: level 2 from level 0, base below default
        drive("R6 R5", 1, 2, 0, 32'h0000_0300, 32'h0000_0100, 32'hFFFF_FF0F, 32'h0000_0044, 32'h1000_0000);
        // R1: equal level rejected
        drive("R1 equal", 1, 3, 3, 32'h0000_F000, 32'hFFFF_FFFF, 32'h0, 32'h100, 32'h0);
        // R1: lower level rejected
        drive("R1 lower", 1, 2, 4, 32'h0000_0F00, 32'hFFFF_FFFF, 32'h0, 32'h100, 32'h0);
        // R2: level above NLEVELS rejected
        drive("R2 over", 1, 7, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h100, 32'h0);
        drive("R2 max", 1, 15, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h100, 32'h0);
        // R3: disabled line, and line of another level
        drive("R3 disabled", 1, 3, 0, 32'h0000_1000, 32'hFFFF_EFFF, 32'h0, 32'h100, 32'h0);
        drive("R3 other lvl", 1, 3, 0, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0, 32'h100, 32'h0);
        // R7 R9: level 1 user exception
        drive("R7 R9 user", 1, 1, 0, 32'h0000_0020, 32'hFFFF_FFFF, 32'h0000_0020, 32'h0000_ABC0, 32'h0);
        // R9: level 1 kernel exception
        drive("R9 kernel", 1, 1, 0, 32'h0000_0080, 32'h0000_00F0, 32'h0000_0000, 32'h0000_ABC4, 32'h0);
        // R8: level 1 double exception
        drive("R8 double", 1, 1, 0, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0030, 32'h0000_BEE8, 32'h0);
        // R10: qualifying inputs but no evaluate strobe
        drive("R10 no eval", 0, 4, 0, 32'h000F_0000, 32'hFFFF_FFFF, 32'h0, 32'h200, 32'h0);
        // R4: back to back takes at level 5 then 4
        drive("R4 lvl5", 1, 5, 2, 32'h0010_0000, 32'hFFFF_FFFF, 32'h0000_0042, 32'h0000_5000, 32'h4000_0000);
        drive("R4 lvl4", 1, 4, 3, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_0053, 32'h0000_5004, 32'h4000_1000);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule